// File: doc/BRIEF.md
# Deadline Compare Timer Bank

This unit holds three 64-bit processor timers: a core tick timer, a system tick timer and a hyperprivileged system tick timer. Each one has a counter that advances by one on every cycle where the shared tick strobe is high. Software can load the counter and read it back. Each timer also has a one-shot deadline register. When the counter reaches an armed deadline while the timer is enabled, the unit sets a bit in a soft-interrupt register and pulses a wake output to bring a halted core out of its halted state.

The top bit of a timer word is not part of the count. It is a per-timer disable flag, and writes to either the counter or the deadline update it. A counter read returns the flag in that top bit. The deadline does not repeat: software writes a new deadline for each interrupt it wants. A deadline of zero, or a write that disables the timer, cancels any pending expiry. A deadline that is already at or behind the count fires on the next tick instead of waiting for the counter to wrap. Soft-interrupt bits stay set until software clears them through a write-one-to-clear port.

Top module: `deadline_timer_unit`

## Requirements
- R1: A counter write (`wr_en`=1, `wr_deadline`=0) loads `wr_data[62:0]` into the counter of timer `wr_sel` (0 = tick, 1 = system tick, 2 = hyperprivileged; 3 is ignored). On every cycle where `tick_en`=1, each counter that is not being written that cycle increases by one.
- R2: `rd_data` is registered. One clock edge after `rd_sel` is applied it shows the selected timer's counter in bits 62:0 and its disable flag in bit 63.
- R3: Bit 63 of a counter write and bit 63 of a deadline write (`wr_deadline`=1) both set or clear the same per-timer disable flag.
- R4: When an armed, enabled timer's counter advances onto its deadline at a `tick_en` edge, the timer's soft-interrupt bit is set at that same edge, and `wake` is high for exactly the following cycle.
- R5: A deadline fires at most once. A counter that passes the same value again without a new deadline write produces no interrupt.
- R6: A deadline write whose bits 62:0 are zero, or whose bit 63 is 1, arms nothing. A counter write with bit 63 set cancels any armed deadline.
- R7: A deadline that is less than or equal to the counter value as it stands after the write cycle fires at the first `tick_en` edge that follows.
- R8: Expiry of timer 0 sets `softint` bit 0. Expiry of timer 1 or timer 2 sets `softint` bit 16.
- R9: `softint` bits are cleared by writing ones to `softint_clr`. When a clear and an expiry hit the same bit in the same cycle, the bit ends up set.
- R10: `irq_pending` is 1 exactly when `softint` is nonzero, and it updates on the same edge as `softint`.
- R11: Synchronous reset leaves every timer disabled with a count of zero and no armed deadline, and clears `softint`, `irq_pending` and `wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count strobe shared by all timers |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Timer selected for the write |
| wr_deadline | input | 1 | 1 writes the deadline, 0 writes the counter |
| wr_data | input | 64 | Write data; bit 63 is the disable flag |
| rd_sel | input | 2 | Timer selected for the read |
| rd_data | output | 64 | Registered read of flag and counter |
| softint_clr | input | 32 | Write-one-to-clear mask for softint |
| softint | output | 32 | Soft-interrupt register |
| irq_pending | output | 1 | Any softint bit set |
| wake | output | 1 | One-cycle pulse on each expiry |

## Verification
Two events can land on the same soft-interrupt bit in the same cycle: a write-one-to-clear from software and an expiry from the timer. The bench arms the tick timer with a deadline one step ahead. It then raises the tick strobe in the same cycle as an all-ones clear mask, and expects bit 0 to survive while bit 16, which had been set earlier, drops. A second overlap, a deadline write landing on a count that has already passed it, is provoked by loading the deadline below the counter. That case is judged by whether the interrupt appears on the very next tick.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  localparam int N_TIMERS = 3;
  localparam int SEL_W    = 2;

  // Soft-interrupt bit driven by each timer's expiry.
  function automatic int sint_bit(input int idx);
    return (idx == 0) ? 0 : 16;
  endfunction
endpackage

// File: rtl/dtu_timer.sv
module dtu_timer #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              cnt_wr,
  input  logic              cmp_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              fire_o,
  output logic [DATA_W-1:0] view_o
);
  localparam int CW = DATA_W - 1;

  logic [CW-1:0] cnt_q, dl_q, cnt_nxt, cnt_inc;
  logic          dis_q, armed_q, late_q;
  logic          hit;

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    if (cnt_wr)       cnt_nxt = wr_data[CW-1:0];
    else if (tick_en) cnt_nxt = cnt_inc;
    else              cnt_nxt = cnt_q;
  end

  // Expiry: the tick carries the counter onto the deadline, or the deadline was already behind.
  assign hit = tick_en && !cnt_wr && !cmp_wr && armed_q && !dis_q &&
               (late_q || (cnt_inc == dl_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      dl_q    <= '0;
      dis_q   <= 1'b1;
      armed_q <= 1'b0;
      late_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (cnt_wr) begin
        dis_q <= wr_data[CW];
        if (wr_data[CW]) begin
          armed_q <= 1'b0;
          late_q  <= 1'b0;
        end
      end else if (cmp_wr) begin
        dis_q   <= wr_data[CW];
        dl_q    <= wr_data[CW-1:0];
        armed_q <= (|wr_data[CW-1:0]) && !wr_data[CW];
        late_q  <= (wr_data[CW-1:0] <= cnt_nxt);
      end else if (hit) begin
        armed_q <= 1'b0;
        late_q  <= 1'b0;
      end
    end
  end

  assign fire_o = hit;
  assign view_o = {dis_q, cnt_q};

  assert_reset_state_R11: assert property (@(posedge clk)
    rst |=> (cnt_q == '0) && dis_q && !armed_q);

  assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !cnt_wr) |=> (cnt_q == $past(cnt_inc)));

  assert_count_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !cnt_wr) |=> $stable(cnt_q));

  assert_single_fire_R5: assert property (@(posedge clk) disable iff (rst)
    (fire_o && !cmp_wr) |=> !fire_o);

  assert_disable_cancels_R6: assert property (@(posedge clk) disable iff (rst)
    ((cnt_wr || cmp_wr) && wr_data[CW]) |=> !fire_o);
endmodule

// File: rtl/dtu_softint.sv
module dtu_softint
  import dtu_pkg::*;
#(
  parameter int SINT_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_TIMERS-1:0] fire,
  input  logic [SINT_W-1:0]   clr,
  output logic [SINT_W-1:0]   sint_q,
  output logic                pend_q,
  output logic                wake_q
);
  logic [SINT_W-1:0] set_vec, sint_nxt;

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < N_TIMERS; i++)
      if (fire[i]) set_vec[sint_bit(i)] = 1'b1;
    sint_nxt = (sint_q & ~clr) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sint_q <= '0;
      pend_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      sint_q <= sint_nxt;
      pend_q <= |sint_nxt;
      wake_q <= |fire;
    end
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((sint_q & $past(set_vec)) == $past(set_vec)));

  assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
    (|(clr & ~set_vec)) |=> ((sint_q & $past(clr & ~set_vec)) == '0));

  assert_wake_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    (|fire) |=> wake_q);

  assert_pending_R10: assert property (@(posedge clk) disable iff (rst)
    pend_q == (|sint_q));
endmodule

// File: rtl/deadline_timer_unit.sv
module deadline_timer_unit
  import dtu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SINT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              wr_deadline,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic [SINT_W-1:0] softint_clr,
  output logic [SINT_W-1:0] softint,
  output logic              irq_pending,
  output logic              wake
);
  logic [N_TIMERS-1:0] fire;
  logic [DATA_W-1:0]   view [N_TIMERS];
  logic [DATA_W-1:0]   rd_nxt;

  for (genvar g = 0; g < N_TIMERS; g++) begin : g_tmr
    logic sel_hit;
    assign sel_hit = wr_en && (wr_sel == SEL_W'(g));
    dtu_timer #(.DATA_W(DATA_W)) u_tmr (
      .clk     (clk),
      .rst     (rst),
      .tick_en (tick_en),
      .cnt_wr  (sel_hit && !wr_deadline),
      .cmp_wr  (sel_hit && wr_deadline),
      .wr_data (wr_data),
      .fire_o  (fire[g]),
      .view_o  (view[g])
    );
  end

  always_comb begin
    rd_nxt = '0;
    for (int i = 0; i < N_TIMERS; i++)
      if (rd_sel == SEL_W'(i)) rd_nxt = view[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nxt;
  end

  dtu_softint #(.SINT_W(SINT_W)) u_sint (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire),
    .clr    (softint_clr),
    .sint_q (softint),
    .pend_q (irq_pending),
    .wake_q (wake)
  );
endmodule

// File: tb/tb_deadline_timer_unit.sv
`timescale 1ns/1ps
module tb_deadline_timer_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic        wr_deadline = 1'b0;
  logic [63:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [63:0] rd_data;
  logic [31:0] softint_clr = '0;
  logic [31:0] softint;
  logic        irq_pending, wake;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  localparam logic [63:0] DIS = 64'h8000_0000_0000_0000;

  always #2.5 clk = ~clk;

  deadline_timer_unit dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_deadline(wr_deadline), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .softint_clr(softint_clr), .softint(softint),
    .irq_pending(irq_pending), .wake(wake)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic dl, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_deadline = dl; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [63:0] v);
    @(negedge clk);
    rd_sel = sel;
    @(posedge clk);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic clr(input logic [31:0] m);
    @(negedge clk);
    softint_clr = m;
    @(posedge clk);
    @(negedge clk);
    softint_clr = '0;
  endtask

  task automatic t_reset;
    logic [63:0] v;
    for (int i = 0; i < 3; i++) begin
      rd(2'(i), v);
      check("R11 reset read", v, DIS);
    end
    check("R11 reset softint", 64'(softint), 64'd0);
    check("R11 reset irq", 64'(irq_pending), 64'd0);
    check("R11 reset wake", 64'(wake), 64'd0);
  endtask

  task automatic t_count;
    logic [63:0] v;
    wr(0, 0, 64'd100);
    tk(5);
    rd(0, v); check("R1 R2 count after ticks", v, 64'd105);
    rd(1, v); check("R1 disabled timer still counts", v, DIS | 64'd5);
  endtask

  task automatic t_flag;
    logic [63:0] v;
    wr(1, 0, DIS | 64'd7);
    rd(1, v); check("R3 count write sets flag", v, DIS | 64'd7);
    tk(2);
    rd(1, v); check("R3 flag kept while counting", v, DIS | 64'd9);
    wr(2, 0, 64'd33);
    rd(2, v); check("R3 count write clears flag", v, 64'd33);
    wr(2, 1, DIS | 64'd40);
    rd(2, v); check("R3 deadline write sets shared flag", v, DIS | 64'd33);
  endtask

  task automatic t_fire;
    logic [63:0] v;
    clr('1);
    wr(0, 0, 64'd10);
    wr(0, 1, 64'd13);
    tk(2);
    check("R4 no early fire", 64'(softint), 64'd0);
    tk(1);
    check("R4 R8 softint bit0 on expiry", 64'(softint), 64'd1);
    check("R4 wake pulse", 64'(wake), 64'd1);
    check("R10 irq follows softint", 64'(irq_pending), 64'd1);
    @(negedge clk);
    check("R4 wake one cycle", 64'(wake), 64'd0);
    check("R9 softint holds", 64'(softint), 64'd1);
    rd(0, v); check("R4 count at deadline", v, 64'd13);
  endtask

  task automatic t_oneshot;
    clr('1);
    wr(0, 0, 64'd10);
    tk(4);
    check("R5 no refire without new deadline", 64'(softint), 64'd0);
  endtask

  task automatic t_cancel;
    wr(0, 0, 64'd0);
    wr(0, 1, 64'd0);
    tk(4);
    check("R6 zero deadline never fires", 64'(softint), 64'd0);
    wr(0, 0, 64'd0);
    wr(0, 1, DIS | 64'd3);
    tk(4);
    check("R6 disabled deadline never fires", 64'(softint), 64'd0);
    wr(0, 0, 64'd0);
    wr(0, 1, 64'd3);
    wr(0, 0, DIS);
    wr(0, 0, 64'd0);
    tk(4);
    check("R6 count-write disable cancels", 64'(softint), 64'd0);
  endtask

  task automatic t_late;
    wr(0, 0, 64'd50);
    wr(0, 1, 64'd20);
    tk(1);
    check("R7 past deadline fires next tick", 64'(softint), 64'd1);
    check("R7 wake on late fire", 64'(wake), 64'd1);
    clr('1);
    wr(0, 0, 64'd60);
    wr(0, 1, 64'd60);
    tk(1);
    check("R7 equal deadline fires next tick", 64'(softint), 64'd1);
  endtask

  task automatic t_map;
    clr('1);
    wr(1, 0, 64'd0);
    wr(1, 1, 64'd2);
    tk(2);
    check("R8 timer1 sets bit16", 64'(softint), 64'h1_0000);
    clr('1);
    wr(2, 0, 64'd0);
    wr(2, 1, 64'd1);
    tk(1);
    check("R8 timer2 sets bit16", 64'(softint), 64'h1_0000);
  endtask

  task automatic t_collide;
    wr(0, 0, 64'd0);
    wr(0, 1, 64'd1);
    @(negedge clk);
    tick_en = 1'b1; softint_clr = '1;
    @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0; softint_clr = '0;
    check("R9 set wins over clear", 64'(softint), 64'd1);
    clr(32'd1);
    check("R9 w1c clears", 64'(softint), 64'd0);
    check("R10 irq drops", 64'(irq_pending), 64'd0);
  endtask

  task automatic t_rerst;
    logic [63:0] v;
    wr(0, 0, 64'd0);
    wr(0, 1, 64'd2);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst = 1'b0;
    rd(0, v); check("R11 reset mid-run", v, DIS);
    tk(3);
    check("R11 deadline cancelled by reset", 64'(softint), 64'd0);
    rd(0, v); check("R11 counts from zero", v, DIS | 64'd3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_count();
    t_flag();
    t_fire();
    t_oneshot();
    t_cancel();
    t_late();
    t_map();
    t_collide();
    t_rerst();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule